// File: doc/BRIEF.md
# Integer Add and Scaled-Add Unit

This block is a single-cycle integer execution stage for a 32-bit datapath. Each cycle it may accept one 64-bit instruction word together with two already-fetched operands and the current carry flag. It then performs either a plain add or a scaled add. In a scaled add, operand A is shifted left by an amount taken from the instruction before B is added. The result, four condition flags and a flag write enable appear one clock later, qualified by a valid strobe.

A two-bit modifier field in the instruction has two meanings:
- When exactly one bit is set, each bit independently negates one operand.
- When both bits are set, the field instead requests that one be added to the final result.

Several modifier combinations are not handled. For these the unit raises an unsupported-error strobe and withholds the flag write enable. The result is still produced, so the surrounding pipeline can decide what to do with it.

Top module: `iadd_unit`

## Requirements
- R1: Result is the 32-bit wrapped sum of the prepared operands. It appears on `result_o` with `valid_o` high exactly one clock after `valid_i` is sampled high.
- R2: When instruction bits 49:48 are not both 1, bit 48 replaces operand B by its two's complement and bit 49 does the same for operand A.
- R3: When instruction bits 49:48 equal 3, no operand is negated and 1 is added to the final result.
- R4: When `mode_i` is 0 (plain add) and instruction bit 43 is 1, `carry_i` is added to the sum as 0 or 1. When bit 43 is 0, `carry_i` has no effect.
- R5: When `mode_i` is 1 (scaled add), the possibly negated operand A is shifted left by instruction bits 43:39 (0 to 31) before B is added. Bit 43 then does not select a carry-in.
- R6: Flags accompany every result:
  - zero is set when the result is 0;
  - sign is bit 31 of the result;
  - carry is bit 32 of the full unsigned sum of the two prepared addends plus all increments;
  - overflow is set when both prepared addends have equal bit 31 and result bit 31 differs from it.
- R7: Instruction bit 47 requests a flag update. `flag_we_o` pulses with `valid_o` when bit 47 is set and the request is supported.
- R8: `unsup_o` pulses with `valid_o`, and `flag_we_o` stays low, whenever any of these holds:
  - bit 50 (saturate) is set;
  - bit 47 is set together with plus-one;
  - bit 47 is set together with a plain-mode bit 43;
  - bit 47 is set in scaled mode;
  - plain-mode bit 43 is set together with plus-one.
- R9: With `valid_i` low, `valid_o`, `flag_we_o` and `unsup_o` fall next clock, and result and flags keep their values.
- R10: After reset, `valid_o`, `result_o`, every flag, `flag_we_o` and `unsup_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation request this cycle |
| mode_i | input | 1 | 0 plain add, 1 scaled add |
| insn_i | input | 64 | Instruction word carrying the modifier fields |
| op_a_i | input | 32 | Operand A |
| op_b_i | input | 32 | Operand B |
| carry_i | input | 1 | Current carry flag |
| valid_o | output | 1 | Registered result valid |
| result_o | output | 32 | Sum |
| flag_z_o | output | 1 | Zero flag |
| flag_s_o | output | 1 | Sign flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_we_o | output | 1 | Flags should be written |
| unsup_o | output | 1 | Unsupported modifier combination |

## Verification
The properties assume that `mode_i`, `insn_i` and the operands carry known values whenever `valid_i` is high. They make no assumption about which modifier combinations arrive, so the unsupported paths are exercised in the same way as the legal ones.

The stimulus always drives defined values on every input. It draws instruction words at random with the saturate bit kept rare, so most operations complete normally while every illegal pairing still occurs. Shift amounts cover the full 0 to 31 range, and the directed cases place operand values at the sign and carry boundaries.

// File: rtl/iadd_pkg.sv
package iadd_pkg;
  localparam int unsigned INSN_W  = 64;
  localparam int unsigned SHAMT_W = 5;
  // instruction field positions decoded by this unit
  localparam int unsigned NEG_B_BIT = 48;
  localparam int unsigned NEG_A_BIT = 49;
  localparam int unsigned EXT_BIT   = 43;
  localparam int unsigned UPD_BIT   = 47;
  localparam int unsigned SAT_BIT   = 50;
  localparam int unsigned SH_LO     = 39;

  typedef enum logic {
    MODE_PLAIN  = 1'b0,
    MODE_SCALED = 1'b1
  } add_mode_e;

  typedef struct packed {
    logic               plus_one;
    logic               neg_a;
    logic               neg_b;
    logic               ext;
    logic               upd;
    logic [SHAMT_W-1:0] shamt;
  } dec_t;
endpackage

// File: rtl/iadd_decode.sv
module iadd_decode
  import iadd_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  input  add_mode_e         mode_i,
  output dec_t              dec_o,
  output logic              unsup_o
);
  logic po, scaled;

  always_comb begin
    scaled = (mode_i == MODE_SCALED);
    po     = insn_i[NEG_A_BIT] & insn_i[NEG_B_BIT];

    dec_o.plus_one = po;
    dec_o.neg_a    = ~po & insn_i[NEG_A_BIT];
    dec_o.neg_b    = ~po & insn_i[NEG_B_BIT];
    // bit 43 doubles as shift MSB in scaled mode
    dec_o.ext      = ~scaled & insn_i[EXT_BIT];
    dec_o.upd      = insn_i[UPD_BIT];
    dec_o.shamt    = scaled ? insn_i[SH_LO +: SHAMT_W] : '0;

    unsup_o = insn_i[SAT_BIT]
            | (dec_o.upd & (po | dec_o.ext | scaled))
            | (dec_o.ext & po);
  end
endmodule

// File: rtl/iadd_prep.sv
module iadd_prep
  import iadd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  dec_t              dec_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  logic [DATA_W-1:0] a_neg;

  always_comb begin
    a_neg = dec_i.neg_a ? (~a_i + 1'b1) : a_i;
    a_o   = a_neg << dec_i.shamt;
    b_o   = dec_i.neg_b ? (~b_i + 1'b1) : b_i;
  end
endmodule

// File: rtl/iadd_sum.sv
module iadd_sum #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              inc_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              z_o,
  output logic              s_o,
  output logic              c_o,
  output logic              v_o
);
  localparam int unsigned MSB = DATA_W - 1;
  logic [DATA_W:0] full;

  always_comb begin
    full  = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i}
          + {{DATA_W{1'b0}}, inc_i};
    sum_o = full[MSB:0];
    z_o   = ~|full[MSB:0];
    s_o   = full[MSB];
    c_o   = full[DATA_W];
    v_o   = (a_i[MSB] == b_i[MSB]) & (full[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/iadd_unit.sv
module iadd_unit
  import iadd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              mode_i,
  input  logic [63:0]       insn_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              carry_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              flag_z_o,
  output logic              flag_s_o,
  output logic              flag_c_o,
  output logic              flag_v_o,
  output logic              flag_we_o,
  output logic              unsup_o
);
  dec_t              dec;
  logic              unsup;
  logic [DATA_W-1:0] a_p, b_p, sum;
  logic              z, s, c, v;

  iadd_decode u_dec (
    .insn_i  (insn_i),
    .mode_i  (add_mode_e'(mode_i)),
    .dec_o   (dec),
    .unsup_o (unsup)
  );

  iadd_prep #(.DATA_W(DATA_W)) u_prep (
    .a_i   (op_a_i),
    .b_i   (op_b_i),
    .dec_i (dec),
    .a_o   (a_p),
    .b_o   (b_p)
  );

  iadd_sum #(.DATA_W(DATA_W)) u_sum (
    .a_i   (a_p),
    .b_i   (b_p),
    .cin_i (dec.ext & carry_i),
    .inc_i (dec.plus_one),
    .sum_o (sum),
    .z_o   (z),
    .s_o   (s),
    .c_o   (c),
    .v_o   (v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      flag_we_o <= 1'b0;
      unsup_o   <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      flag_we_o <= valid_i & dec.upd & ~unsup;
      unsup_o   <= valid_i & unsup;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      flag_z_o <= 1'b0;
      flag_s_o <= 1'b0;
      flag_c_o <= 1'b0;
      flag_v_o <= 1'b0;
    end else if (valid_i) begin
      result_o <= sum;
      flag_z_o <= z;
      flag_s_o <= s;
      flag_c_o <= c;
      flag_v_o <= v;
    end
  end
endmodule

// File: rtl/iadd_unit_chk.sv
module iadd_unit_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              mode_i,
  input logic [63:0]       insn_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              flag_z_o,
  input logic              flag_s_o,
  input logic              flag_we_o,
  input logic              unsup_o
);
  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_idle_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !flag_we_o && !unsup_o));

  p_hold_res_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));

  p_we_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> (valid_o && !unsup_o));

  p_sat_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && insn_i[50]) |=> (unsup_o && !flag_we_o));

  p_scaled_upd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i && insn_i[47]) |=> unsup_o);

  p_zero_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (flag_z_o == (result_o == '0)));

  p_sign_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (flag_s_o == result_o[DATA_W-1]));
endmodule

bind iadd_unit iadd_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .mode_i    (mode_i),
  .insn_i    (insn_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .flag_z_o  (flag_z_o),
  .flag_s_o  (flag_s_o),
  .flag_we_o (flag_we_o),
  .unsup_o   (unsup_o)
);

// File: tb/iadd_unit_tb_top.sv
`timescale 1ns/1ps
module iadd_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [63:0] insn_i = '0;
  logic [31:0] op_a_i = '0;
  logic [31:0] op_b_i = '0;
  logic        carry_i = 1'b0;
  logic        valid_o, flag_z_o, flag_s_o, flag_c_o, flag_v_o, flag_we_o, unsup_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  iadd_unit dut_i (.*);

  typedef struct packed {
    logic [31:0] r;
    logic z, s, c, v, we, un;
  } exp_t;

  function automatic exp_t model(input logic [63:0] w, input logic m,
                                 input logic [31:0] a, input logic [31:0] b,
                                 input logic ci);
    exp_t e;
    logic po, na, nb, x;
    logic [4:0]  sh;
    logic [31:0] aa, bb;
    logic [32:0] full;
    po = w[49] & w[48];
    na = !po && w[49];
    nb = !po && w[48];
    x  = !m && w[43];
    sh = m ? w[43:39] : 5'd0;
    aa = na ? (32'd0 - a) : a;
    aa = aa << sh;
    bb = nb ? (32'd0 - b) : b;
    full = {1'b0, aa} + {1'b0, bb} + 33'(x & ci) + 33'(po);
    e.r  = full[31:0];
    e.z  = (full[31:0] == 0);
    e.s  = full[31];
    e.c  = full[32];
    e.v  = (aa[31] == bb[31]) && (full[31] != aa[31]);
    e.un = w[50] | (w[47] & (po | x | m)) | (x & po);
    e.we = w[47] & !e.un;
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, check outputs at next negedge
  task automatic run(input logic m, input logic [63:0] w, input logic [31:0] a,
                     input logic [31:0] b, input logic ci);
    exp_t e;
    string t;
    e = model(w, m, a, b, ci);
    valid_i = 1'b1; mode_i = m; insn_i = w; op_a_i = a; op_b_i = b; carry_i = ci;
    @(negedge clk_i);
    valid_i = 1'b0;
    if (m) t = "R5";
    else if (w[49] & w[48]) t = "R3";
    else if (w[43]) t = "R4";
    else if (w[49] | w[48]) t = "R2";
    else t = "R1";
    chk("R1 valid", 32'(valid_o), 32'd1);
    chk(t, result_o, e.r);
    chk("R6 flags", {28'd0, flag_z_o, flag_s_o, flag_c_o, flag_v_o},
        {28'd0, e.z, e.s, e.c, e.v});
    chk("R7 we", 32'(flag_we_o), 32'(e.we));
    chk("R8 unsup", 32'(unsup_o), 32'(e.un));
  endtask

  function automatic logic [63:0] fld(input int pos);
    return 64'd1 << pos;
  endfunction

  initial begin
    logic [31:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    chk("R10 reset", {24'd0, valid_o, flag_z_o, flag_s_o, flag_c_o, flag_v_o,
                      flag_we_o, unsup_o, 1'b0}, 32'd0);
    chk("R10 reset result", result_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run(0, 64'd0, 32'd5, 32'd7, 1'b0);                        // R1: 12
    run(0, fld(48), 32'd5, 32'd7, 1'b0);                      // R2: -2
    run(0, fld(49), 32'd5, 32'd7, 1'b0);                      // R2: 2
    run(0, fld(48) | fld(49), 32'd5, 32'd7, 1'b0);            // R3: 13
    run(0, fld(43), 32'd5, 32'd7, 1'b1);                      // R4: 13
    run(0, fld(43), 32'd5, 32'd7, 1'b0);                      // R4: 12
    run(0, 64'd0, 32'd5, 32'd7, 1'b1);                        // R4 carry ignored
    run(1, 64'(4) << 39, 32'd3, 32'd1, 1'b1);                 // R5: 49
    run(1, (64'(31) << 39) | fld(49), 32'd1, 32'd0, 1'b0);    // R5 shift 31 of -1
    run(0, fld(47), 32'h7fffffff, 32'd1, 1'b0);               // R6 V,S
    run(0, fld(47), 32'hffffffff, 32'd1, 1'b0);               // R6 Z,C
    run(0, fld(50), 32'd1, 32'd2, 1'b0);                      // R8 sat
    run(0, fld(47) | fld(48) | fld(49), 32'd1, 32'd2, 1'b0);  // R8 upd+po
    run(0, fld(47) | fld(43), 32'd1, 32'd2, 1'b1);            // R8 upd+ext
    run(0, fld(43) | fld(48) | fld(49), 32'd1, 32'd2, 1'b1);  // R8 ext+po
    run(1, fld(47), 32'd1, 32'd2, 1'b0);                      // R8 scaled upd

    // R9: idle cycle with changed inputs
    held = result_o;
    op_a_i = 32'hdead; op_b_i = 32'hbeef; insn_i = fld(47);
    @(negedge clk_i);
    chk("R9 valid low", {29'd0, valid_o, flag_we_o, unsup_o}, 32'd0);
    chk("R9 result held", result_o, held);

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] w;
      w = {$urandom, $urandom};
      if ($urandom_range(7) != 0) w[50] = 1'b0;
      run(1'($urandom), w, $urandom, $urandom, 1'($urandom));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule